// File: doc/BRIEF.md
# Serial Controller Status and Error Flag Unit

This block keeps the run-state and error state of a serial controller. It holds an operational-mode bit (set: the controller runs; clear: it is in configuration mode), a master-select bit and six sticky error flags: mode error, transmit overflow, receive overflow, abort, transmit underflow and receive underflow. Software reads a status view and changes the state through a write-only command word. Each state bit has one bit in that word that sets it and another that clears it. Changing one bit therefore never needs a read-modify-write, and one write can clear all errors at once.

The shift engine detects errors. It reports them as single-cycle pulses on `err_evt`, one line per flag. A control register holds one enable bit for each of five error kinds; a pulse whose enable is off is dropped. The mode-error pulse has no enable and is always taken. `err_irq` is high while any error flag is set. The bus side is a single-cycle write port and a combinational read port selected by `wr_addr` and `rd_addr`: 0 is the control register, 1 is the status view and 2 is the command word.

Top module: `ssc_status_unit`

## Requirements
- R1: After reset the status view, the control register, `op_mode`, `master_sel` and `err_irq` are all zero.
- R2: In a command write, bit 1 sets and bit 0 clears the operational-mode bit, and bit 3 sets and bit 2 clears master-select. Both bits appear at status bits 0 and 1 and on `op_mode` and `master_sel` from the cycle after the write.
- R3: Command set bits act as follows: bit 7 sets mode error, bits 12, 13, 14 and 15 set transmit overflow, receive overflow, abort and transmit underflow, and bit 5 sets receive underflow. The flags read back at status bits 7, 8, 9, 10, 11 and 12 in that order.
- R4: Command clear bits act as follows: bit 6 clears mode error, bits 8 to 11 clear transmit overflow, receive overflow, abort and transmit underflow, and bit 4 clears receive underflow. A write of 0x0F50 clears all six flags at once. Command bits that are zero leave their flags unchanged.
- R5: When one write carries both the set bit and the clear bit of the same state bit, the state bit ends up clear.
- R6: `err_evt` index 0 is mode error, 1 transmit overflow, 2 receive overflow, 3 abort, 4 transmit underflow and 5 receive underflow. A pulse sets its flag in the next cycle when its enable is on. Control bits 8, 9, 10, 11 and 12 enable indices 1 to 5, and index 0 is always enabled.
- R7: A pulse whose control enable bit is zero does not change its flag.
- R8: An enabled error pulse that arrives in the same cycle as a clear strobe for that flag leaves the flag set.
- R9: `err_irq` is the OR of the six error flags. It stays high through idle cycles and through later changes to the control enables, until a clear strobe removes the flags.
- R10: Control bits 12 to 8 read back as written and all other control bits read as zero. Status bit 13 shows the `busy` input in the same cycle. Reading the command address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| wr_addr | input | 2 | Write target: 0 control, 2 command |
| wr_data | input | DW | Write data |
| rd_addr | input | 2 | Read target: 0 control, 1 status, 2 command (reads zero) |
| rd_data | output | DW | Combinational read data |
| err_evt | input | 6 | Error pulses from the shift engine |
| busy | input | 1 | Shift engine busy level, shown in status |
| op_mode | output | 1 | Operational-mode bit |
| master_sel | output | 1 | Master-select bit |
| err_irq | output | 1 | Combined error interrupt |

## Verification
The bench goes after the collisions in each flag's next-state rule. It drives set and clear bits for the same flag in one write, where a design that lets set win would leave stale flags after cleanup. It also drives an error pulse in the same cycle as a clear, where a design that lets clear win would lose a real error. It runs gated pulses with enables off, partly on and fully on, and checks that mode error always gets through. A swapped enable position would set the wrong flag, and a wrong gate would let a masked error raise the interrupt. It checks that the interrupt stays high after the enables are turned off, so that an interrupt derived from the enables rather than from the flags is caught.

// File: rtl/ssc_stat_pkg.sv
package ssc_stat_pkg;
  localparam int NERR  = 6;   // mode, tx ovf, rx ovf, abort, tx unf, rx unf
  localparam int CMD_W = 16;
  localparam int ST_EN  = 0;
  localparam int ST_MS  = 1;
  localparam int ST_BSY = 13;
  localparam int CMD_EN_CLR = 0;
  localparam int CMD_EN_SET = 1;
  localparam int CMD_MS_CLR = 2;
  localparam int CMD_MS_SET = 3;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CMD  = 2'd2
  } reg_sel_e;

  // Command bit that clears error flag i
  function automatic int clr_bit(input int i);
    if (i == 0) return 6;
    if (i == NERR - 1) return 4;
    return 7 + i;
  endfunction

  // Command bit that sets error flag i
  function automatic int set_bit(input int i);
    if (i == 0) return 7;
    if (i == NERR - 1) return 5;
    return 11 + i;
  endfunction

  // Status position of error flag i; the same position holds its enable in control
  function automatic int stat_bit(input int i);
    return 7 + i;
  endfunction

  // Whether error i passes through a control enable (mode error does not)
  function automatic bit has_gate(input int i);
    return i != 0;
  endfunction
endpackage

// File: rtl/ssc_cmd_decode.sv
module ssc_cmd_decode
  import ssc_stat_pkg::*;
(
  input  logic             strobe,
  input  logic [CMD_W-1:0] data,
  output logic [NERR-1:0]  err_set,
  output logic [NERR-1:0]  err_clr,
  output logic             en_set,
  output logic             en_clr,
  output logic             ms_set,
  output logic             ms_clr
);
  assign en_set = strobe & data[CMD_EN_SET];
  assign en_clr = strobe & data[CMD_EN_CLR];
  assign ms_set = strobe & data[CMD_MS_SET];
  assign ms_clr = strobe & data[CMD_MS_CLR];

  for (genvar g = 0; g < NERR; g++) begin : g_err
    localparam int SB = set_bit(g);
    localparam int CB = clr_bit(g);
    assign err_set[g] = strobe & data[SB];
    assign err_clr[g] = strobe & data[CB];
  end
endmodule

// File: rtl/ssc_sticky_bit.sv
module ssc_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic hw_evt,
  output logic q
);
  // hardware event > software clear > software set > hold
  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= hw_evt | (~sw_clr & (q | sw_set));
  end

  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_set && !sw_clr) |=> q);
  p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr && !hw_evt) |=> !q);
  p_event_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hw_evt |=> q);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_set && !sw_clr && !hw_evt) |=> $stable(q));
endmodule

// File: rtl/ssc_err_ctrl.sv
module ssc_err_ctrl
  import ssc_stat_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [NERR-2:0] en_wdata,   // write data bits 12..8
  output logic [DW-1:0]   view,
  output logic [NERR-1:0] gate
);
  logic [NERR-2:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  en_q <= '0;
    else if (wr) en_q <= en_wdata;
  end

  always_comb begin
    view = '0;
    for (int i = 1; i < NERR; i++) view[stat_bit(i)] = en_q[i-1];
  end

  for (genvar g = 0; g < NERR; g++) begin : g_gate
    if (has_gate(g)) begin : g_en
      assign gate[g] = en_q[g-1];
    end else begin : g_always
      assign gate[g] = 1'b1;
    end
  end

  p_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (en_q == $past(en_wdata)));
  p_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(en_q));
endmodule

// File: rtl/ssc_status_unit.sv
module ssc_status_unit
  import ssc_stat_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [1:0]      rd_addr,
  output logic [DW-1:0]   rd_data,
  input  logic [NERR-1:0] err_evt,
  input  logic            busy,
  output logic            op_mode,
  output logic            master_sel,
  output logic            err_irq
);
  localparam int EN_LO = stat_bit(1);
  localparam int EN_HI = stat_bit(NERR - 1);

  logic            cmd_wr, ctl_wr;
  logic [NERR-1:0] err_set, err_clr, err_gate, hw_ok, flag_q;
  logic            en_set, en_clr, ms_set, ms_clr;
  logic [DW-1:0]   ctrl_view, stat_view;
  logic            unused_hi;

  assign cmd_wr    = wr_en && (reg_sel_e'(wr_addr) == SEL_CMD);
  assign ctl_wr    = wr_en && (reg_sel_e'(wr_addr) == SEL_CTRL);
  assign unused_hi = ^wr_data[DW-1:CMD_W];

  ssc_cmd_decode u_dec (
    .strobe (cmd_wr),
    .data   (wr_data[CMD_W-1:0]),
    .err_set(err_set),
    .err_clr(err_clr),
    .en_set (en_set),
    .en_clr (en_clr),
    .ms_set (ms_set),
    .ms_clr (ms_clr)
  );

  ssc_err_ctrl #(.DW(DW)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (ctl_wr),
    .en_wdata(wr_data[EN_HI:EN_LO]),
    .view    (ctrl_view),
    .gate    (err_gate)
  );

  assign hw_ok = err_evt & err_gate;

  ssc_sticky_bit u_en (
    .clk(clk), .rst_n(rst_n), .sw_set(en_set), .sw_clr(en_clr),
    .hw_evt(1'b0), .q(op_mode)
  );
  ssc_sticky_bit u_ms (
    .clk(clk), .rst_n(rst_n), .sw_set(ms_set), .sw_clr(ms_clr),
    .hw_evt(1'b0), .q(master_sel)
  );

  for (genvar g = 0; g < NERR; g++) begin : g_flag
    ssc_sticky_bit u_f (
      .clk(clk), .rst_n(rst_n), .sw_set(err_set[g]), .sw_clr(err_clr[g]),
      .hw_evt(hw_ok[g]), .q(flag_q[g])
    );

    p_masked_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!err_gate[g] && !err_set[g] && !flag_q[g]) |=> !flag_q[g]);
    p_enabled_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (err_evt[g] && err_gate[g]) |=> flag_q[g]);
  end

  assign err_irq = |flag_q;

  always_comb begin
    stat_view         = '0;
    stat_view[ST_EN]  = op_mode;
    stat_view[ST_MS]  = master_sel;
    stat_view[ST_BSY] = busy;
    for (int i = 0; i < NERR; i++) stat_view[stat_bit(i)] = flag_q[i];
  end

  always_comb begin
    case (reg_sel_e'(rd_addr))
      SEL_CTRL: rd_data = ctrl_view;
      SEL_STAT: rd_data = stat_view;
      default:  rd_data = '0;
    endcase
  end

  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_irq && (err_clr == '0)) |=> err_irq);
  p_clear_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_clr == '1) && (hw_ok == '0)) |=> !err_irq);
endmodule

// File: tb/sim_ssc_status_unit.sv
`timescale 1ns/100ps
module sim_ssc_status_unit;
  localparam logic [1:0] A_CTL = 2'd0, A_ST = 2'd1, A_CMD = 2'd2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [5:0]  err_evt = '0;
  logic        busy = 1'b0, op_mode, master_sel, err_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ssc_status_unit u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .err_evt(err_evt), .busy(busy), .op_mode(op_mode),
    .master_sel(master_sel), .err_irq(err_irq)
  );

  typedef struct {
    logic [1:0]  a;
    logic [31:0] v;
    logic        irq;
    string       tag;
  } item_t;
  item_t q[$];

  // Monitor: pops expected items, reads the design, compares
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q[0];
        rd_addr = it.a;
        #0.5;
        checks++;
        if (rd_data !== it.v) begin
          errors++;
          $display("FAIL %s addr=%0d rd_data actual=%h expected=%h", it.tag, it.a, rd_data, it.v);
        end
        checks++;
        if (err_irq !== it.irq) begin
          errors++;
          $display("FAIL %s err_irq actual=%b expected=%b", it.tag, err_irq, it.irq);
        end
        void'(q.pop_front());
      end
    end
  end

  task automatic expect_rd(input logic [1:0] a, input logic [31:0] v, input logic irq, input string tag);
    item_t it;
    it.a = a; it.v = v; it.irq = irq; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
    @(posedge clk); #1;
  endtask

  task automatic expect_pin(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [1:0] a, input logic [31:0] d, input logic [5:0] ev);
    wr_en = we; wr_addr = a; wr_data = d; err_evt = ev;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_data = '0; err_evt = '0;
  endtask

  task automatic cmd(input logic [31:0] d);
    cyc(1'b1, A_CMD, d, 6'b0);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    expect_rd(A_ST, 32'h0, 1'b0, "R1 status");
    expect_rd(A_CTL, 32'h0, 1'b0, "R1 control");
    expect_pin(op_mode, 1'b0, "R1 op_mode");
    expect_pin(master_sel, 1'b0, "R1 master_sel");

    // R2 mode and master select
    cmd(32'h0002);
    expect_pin(op_mode, 1'b1, "R2 op_mode set");
    expect_rd(A_ST, 32'h1, 1'b0, "R2 enable set");
    cmd(32'h0008);
    expect_pin(master_sel, 1'b1, "R2 master_sel set");
    expect_rd(A_ST, 32'h3, 1'b0, "R2 master set");
    cmd(32'h0001);
    expect_rd(A_ST, 32'h2, 1'b0, "R2 enable clear");
    cmd(32'h0004);
    expect_pin(master_sel, 1'b0, "R2 master_sel clear");
    expect_rd(A_ST, 32'h0, 1'b0, "R2 master clear");

    // R3 software set strobes, one flag at a time
    cmd(32'h0080); expect_rd(A_ST, 32'h0080, 1'b1, "R3 set mode error");
    cmd(32'h1000); expect_rd(A_ST, 32'h0180, 1'b1, "R3 set tx overflow");
    cmd(32'h2000); expect_rd(A_ST, 32'h0380, 1'b1, "R3 set rx overflow");
    cmd(32'h4000); expect_rd(A_ST, 32'h0780, 1'b1, "R3 set abort");
    cmd(32'h8000); expect_rd(A_ST, 32'h0F80, 1'b1, "R3 set tx underflow");
    cmd(32'h0020); expect_rd(A_ST, 32'h1F80, 1'b1, "R3 set rx underflow");

    // R4 clears
    cmd(32'h0000); expect_rd(A_ST, 32'h1F80, 1'b1, "R4 zero command holds");
    cmd(32'h0010); expect_rd(A_ST, 32'h0F80, 1'b1, "R4 clear rx underflow");
    cmd(32'h0040); expect_rd(A_ST, 32'h0F00, 1'b1, "R4 clear mode error");
    cmd(32'h0F50); expect_rd(A_ST, 32'h0000, 1'b0, "R4 clear all");

    // R5 clear wins over set in the same write
    cmd(32'h8800); expect_rd(A_ST, 32'h0, 1'b0, "R5 tx underflow set+clear");
    cmd(32'h0002);
    cmd(32'h0003); expect_rd(A_ST, 32'h0, 1'b0, "R5 enable set+clear");
    cmd(32'h00C0); expect_rd(A_ST, 32'h0, 1'b0, "R5 mode error set+clear");

    // R10 control read-back
    cyc(1'b1, A_CTL, 32'hFFFF_FFFF, 6'b0);
    expect_rd(A_CTL, 32'h1F00, 1'b0, "R10 control masked readback");
    expect_rd(A_CMD, 32'h0, 1'b0, "R10 command reads zero");

    // R6 enabled hardware events
    cyc(1'b0, A_CTL, 32'h0, 6'b000001); expect_rd(A_ST, 32'h0080, 1'b1, "R6 event mode error");
    cyc(1'b0, A_CTL, 32'h0, 6'b100000); expect_rd(A_ST, 32'h1080, 1'b1, "R6 event rx underflow");
    cyc(1'b0, A_CTL, 32'h0, 6'b111111); expect_rd(A_ST, 32'h1F80, 1'b1, "R6 all events");
    cmd(32'h0F50);

    // R7 disabled events ignored, mode error still taken
    cyc(1'b1, A_CTL, 32'h0, 6'b0);
    cyc(1'b0, A_CTL, 32'h0, 6'b111110); expect_rd(A_ST, 32'h0, 1'b0, "R7 masked events ignored");
    cyc(1'b0, A_CTL, 32'h0, 6'b000001); expect_rd(A_ST, 32'h0080, 1'b1, "R6 mode error ungated");
    cmd(32'h0F50);
    cyc(1'b1, A_CTL, 32'h0400, 6'b0);
    cyc(1'b0, A_CTL, 32'h0, 6'b111110); expect_rd(A_ST, 32'h0400, 1'b1, "R7 only abort enabled");
    cmd(32'h0F50);

    // R8 event beats clear in the same cycle
    cyc(1'b1, A_CTL, 32'h1F00, 6'b0);
    cmd(32'h2000);
    cyc(1'b1, A_CMD, 32'h0F50, 6'b000100);
    expect_rd(A_ST, 32'h0200, 1'b1, "R8 event with clear keeps rx overflow");

    // R9 interrupt holds through idle and enable changes
    repeat (3) cyc(1'b0, A_CTL, 32'h0, 6'b0);
    expect_rd(A_ST, 32'h0200, 1'b1, "R9 irq holds idle");
    cyc(1'b1, A_CTL, 32'h0, 6'b0);
    expect_rd(A_ST, 32'h0200, 1'b1, "R9 irq holds after disable");
    cmd(32'h0200);
    expect_rd(A_ST, 32'h0, 1'b0, "R9 irq drops on clear");

    // R10 busy in status
    busy = 1'b1;
    expect_rd(A_ST, 32'h2000, 1'b0, "R10 busy visible");
    busy = 1'b0;
    expect_rd(A_ST, 32'h0, 1'b0, "R10 busy low");

    done = 1;
    summary();
    $finish;
  end
endmodule